// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It follows four test pins: a test clock, a mode select, a data input and an optional active-low port reset. It steps a sixteen-state controller, holds a 4-bit instruction, and owns two small data registers: a one-bit pass-through stage and a 32-bit identification word. It decides which of these, or the external boundary chain, feeds the serial output, and it drives the output enable.

Boundary cells sit outside the block. The block gives them capture, shift and update strobes, a two-bit register select, and three mode controls. One control hands the pins to the boundary latches. One hands the core inputs to the latches. One forces every pin driver off. The boundary chain's serial output comes back in through `bsr_tdo`. The two clamp instructions keep the pins held from the latches while only the one-bit stage sits in the scan path. This lets a board shorten its chains while a guard pattern stays applied.

Top module: `jtag_tap`

## Requirements
- R1: While `trst_n` is low, and right after it rises, the active instruction is IDCODE: `dr_sel`=2, the three mode controls are 0 and `tdo_en`=0.
- R2: Five rising clock edges with `tms`=1 reach Test-Logic-Reset from any state. One clock in that state loads IDCODE (1110) as the active instruction.
- R3: The active opcode decodes as follows, with `dr_sel` 0=bypass, 1=boundary chain, 2=identification. 1111 BYPASS gives sel 0 and no controls. 1110 IDCODE gives sel 2. 0011 SAMPLE gives sel 1 and no controls. 0000 EXTEST gives sel 1 and pin_test. 1100 INTEST gives sel 1 and core_test. 0101 CLAMP gives sel 0 and pin_test. 1001 CLAMPZ gives sel 0, pin_test and hiz. Every other code acts as BYPASS.
- R4: Capture-IR loads 0001 into the instruction shift stage. Shift-IR moves it out least significant bit first, taking `tdi` in at the top.
- R5: A shifted opcode becomes active only at Update-IR. Until then the decode outputs keep the previous instruction.
- R6: With IDCODE active, a data scan shifts out the 32-bit identification value `IDCODE_VAL` (default 32'h1B5C_3E2F), least significant bit first.
- R7: With a bypass-selecting instruction, Capture-DR loads 0. Each shift then outputs the `tdi` bit taken one clock earlier.
- R8: `tdo` and `tdo_en` change only on the falling clock edge. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R9: `capture_dr`, `shift_dr` and `update_dr` are each high exactly in the Capture-DR, Shift-DR and Update-DR states, and never together.
- R10: With a boundary-chain instruction active, `tdo` in Shift-DR presents `bsr_tdo` as sampled at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_en | output | 1 | Output enable for tdo |
| capture_dr | output | 1 | Data register capture strobe |
| shift_dr | output | 1 | Data register shift strobe |
| update_dr | output | 1 | Data register update strobe |
| dr_sel | output | 2 | Selected data register (0 bypass, 1 boundary, 2 identification) |
| bs_pin_test | output | 1 | Pins driven from boundary latches |
| bs_core_test | output | 1 | Core inputs driven from boundary latches |
| bs_hiz | output | 1 | All boundary output drivers disabled |

## Verification
The assertions assume that `tms` and `tdi` are stable around each rising edge, and that `trst_n` is low at time zero so that every register starts from a known value. The bench changes inputs one nanosecond after a falling edge and samples there, which keeps every change away from both clock edges. The port reset is pulsed only between edges. The checks on the opcode sweep and the clamp codes rely on the controller being walked through complete, legal state paths from Run-Test/Idle.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0011;
    localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0101;
    localparam logic [IR_W-1:0] OP_CLAMPZ = 4'b1001;
    localparam logic [IR_W-1:0] OP_INTEST = 4'b1100;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b1110;
    localparam logic [IR_W-1:0] IR_CAPT   = 4'b0001;

    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_BSR    = 2'd1,
        SEL_ID     = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    pin_test;
        logic    core_test;
        logic    hiz;
    } ir_dec_t;

    function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
        ir_dec_t r;
        r = '{sel: SEL_BYPASS, pin_test: 1'b0, core_test: 1'b0, hiz: 1'b0};
        case (op)
            OP_EXTEST: begin r.sel = SEL_BSR; r.pin_test = 1'b1; end
            OP_SAMPLE: r.sel = SEL_BSR;
            OP_INTEST: begin r.sel = SEL_BSR; r.core_test = 1'b1; end
            OP_CLAMP:  r.pin_test = 1'b1;
            OP_CLAMPZ: begin r.pin_test = 1'b1; r.hiz = 1'b1; end
            OP_IDCODE: r.sel = SEL_ID;
            default:   r.sel = SEL_BYPASS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);
    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_hold,
    output logic [IR_W-1:0] ir_shift
);
    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] hold;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:  r_d.hold = OP_IDCODE;
            ST_CAP_IR: r_d.sr   = IR_CAPT;
            ST_SH_IR:  r_d.sr   = {tdi, r_q.sr[IR_W-1:1]};
            ST_UPD_IR: r_d.hold = r_q.sr;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sr: IR_CAPT, hold: OP_IDCODE};
        else         r_q <= r_d;
    end

    assign ir_hold  = r_q.hold;
    assign ir_shift = r_q.sr;
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          ID_W       = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1B5C_3E2F
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  dr_sel_e    sel,
    input  logic       tdi,
    output logic       bypass_bit,
    output logic       id_out
);
    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            if (sel == SEL_BYPASS) r_d.byp = 1'b0;
            if (sel == SEL_ID)     r_d.id  = IDCODE_VAL[ID_W-1:0];
        end else if (state == ST_SH_DR) begin
            if (sel == SEL_BYPASS) r_d.byp = tdi;
            if (sel == SEL_ID)     r_d.id  = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign bypass_bit = r_q.byp;
    assign id_out     = r_q.id[0];
endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int          ID_W       = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1B5C_3E2F
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    input  logic       bsr_tdo,
    output logic       tdo,
    output logic       tdo_en,
    output logic       capture_dr,
    output logic       shift_dr,
    output logic       update_dr,
    output logic [1:0] dr_sel,
    output logic       bs_pin_test,
    output logic       bs_core_test,
    output logic       bs_hiz
);
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    tap_state_e      tap_state;
    logic [IR_W-1:0] ir_hold;
    logic [IR_W-1:0] ir_shift;
    logic            bypass_bit;
    logic            id_out;
    ir_dec_t         dec;
    out_regs_t       o_d, o_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (tap_state)
    );

    tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (tap_state),
        .tdi      (tdi),
        .ir_hold  (ir_hold),
        .ir_shift (ir_shift)
    );

    assign dec = decode_op(ir_hold);

    tap_dr #(
        .ID_W       (ID_W),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .state      (tap_state),
        .sel        (dec.sel),
        .tdi        (tdi),
        .bypass_bit (bypass_bit),
        .id_out     (id_out)
    );

    always_comb begin
        o_d.en = (tap_state == ST_SH_DR) || (tap_state == ST_SH_IR);
        if (tap_state == ST_SH_IR) begin
            o_d.tdo = ir_shift[0];
        end else begin
            case (dec.sel)
                SEL_BSR: o_d.tdo = bsr_tdo;
                SEL_ID:  o_d.tdo = id_out;
                default: o_d.tdo = bypass_bit;
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo          = o_q.tdo;
    assign tdo_en       = o_q.en;
    assign capture_dr   = (tap_state == ST_CAP_DR);
    assign shift_dr     = (tap_state == ST_SH_DR);
    assign update_dr    = (tap_state == ST_UPD_DR);
    assign dr_sel       = dec.sel;
    assign bs_pin_test  = dec.pin_test;
    assign bs_core_test = dec.core_test;
    assign bs_hiz       = dec.hiz;
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_hold,
    input logic [IR_W-1:0] ir_shift,
    input logic            bypass_bit,
    input logic            tdo_en,
    input logic            capture_dr,
    input logic            shift_dr,
    input logic            update_dr,
    input logic [1:0]      dr_sel,
    input logic            bs_pin_test,
    input logic            bs_hiz
);
    // R2: a clock spent in Test-Logic-Reset leaves IDCODE active
    assert_reset_state_idcode_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_hold == OP_IDCODE));

    // R4: Capture-IR loads the fixed pattern
    assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_shift == IR_CAPT));

    // R5: the active instruction moves only through Update-IR or reset
    assert_ir_stable_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_hold));

    // R7: bypass stage captures zero
    assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (capture_dr && dr_sel == 2'd0) |=> (bypass_bit == 1'b0));

    // R8: output enable follows the shift states (set at the prior falling edge)
    assert_tdo_en_R8: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == ST_SH_DR || state == ST_SH_IR));

    // R9: strobes are mutually exclusive
    assert_strobe_excl_R9: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));

    // R3: driver shutoff only comes with the clamp selection
    assert_hiz_clamp_R3: assert property (@(posedge tck) disable iff (!trst_n)
        bs_hiz |-> (bs_pin_test && dr_sel == 2'd0));
endmodule

bind jtag_tap jtag_tap_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .state      (tap_state),
    .ir_hold    (ir_hold),
    .ir_shift   (ir_shift),
    .bypass_bit (bypass_bit),
    .tdo_en     (tdo_en),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .dr_sel     (dr_sel),
    .bs_pin_test(bs_pin_test),
    .bs_hiz     (bs_hiz)
);

// File: tb/tb_jtag_tap.sv
`timescale 1ns/1ps
module tb_jtag_tap;
    localparam logic [31:0] ID_VAL = 32'h1B5C_3E2F;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
    logic tdo, tdo_en, capture_dr, shift_dr, update_dr;
    logic [1:0] dr_sel;
    logic bs_pin_test, bs_core_test, bs_hiz;
    int checks = 0, errors = 0;

    always #2 tck = ~tck;

    jtag_tap #(.ID_W(32), .IDCODE_VAL(ID_VAL)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
        .tdo(tdo), .tdo_en(tdo_en), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .dr_sel(dr_sel), .bs_pin_test(bs_pin_test),
        .bs_core_test(bs_core_test), .bs_hiz(bs_hiz)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clk(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    // expected decode {sel, pin, core, hiz} straight from the R3 table
    function automatic logic [4:0] exp_dec(input logic [3:0] op);
        case (op)
            4'b0000: return {2'd1, 3'b100};
            4'b0011: return {2'd1, 3'b000};
            4'b1100: return {2'd1, 3'b010};
            4'b0101: return {2'd0, 3'b100};
            4'b1001: return {2'd0, 3'b101};
            4'b1110: return {2'd2, 3'b000};
            default: return {2'd0, 3'b000};
        endcase
    endfunction

    function automatic logic [4:0] obs();
        return {dr_sel, bs_pin_test, bs_core_test, bs_hiz};
    endfunction

    // from Run-Test/Idle: shift op in, stop in Exit1-IR; returns captured bits
    task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            clk(i == 3, op[i]);
        end
    endtask

    task automatic finish_ir();
        clk(1, 0); clk(0, 0);
    endtask

    task automatic load_ir(input logic [3:0] op);
        logic [3:0] c;
        shift_ir(op, c);
        finish_ir();
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            clk(i == n - 1, din[i]);
        end
        clk(1, 0); clk(0, 0);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [3:0]  cap;
        logic [4:0]  prev;
        logic [63:0] dout;

        // R1: reset state
        #5;
        chk(dr_sel == 2'd2, "R1", "dr_sel in reset", dr_sel, 2);
        chk({bs_pin_test, bs_core_test, bs_hiz} == 3'b000, "R1", "controls in reset",
            {bs_pin_test, bs_core_test, bs_hiz}, 0);
        chk(tdo_en == 1'b0, "R1", "tdo_en in reset", tdo_en, 0);
        trst_n = 1'b1;
        clk(1, 0);
        chk(dr_sel == 2'd2, "R1", "dr_sel after release", dr_sel, 2);
        clk(0, 0);   // Run-Test/Idle
        chk(tdo_en == 1'b0, "R8", "tdo_en idle", tdo_en, 0);
        chk({capture_dr, shift_dr, update_dr} == 3'b000, "R9", "strobes idle",
            {capture_dr, shift_dr, update_dr}, 0);

        // R3/R4/R5: sweep every opcode
        prev = exp_dec(4'b1110);
        for (int op = 0; op < 16; op++) begin
            shift_ir(op[3:0], cap);
            chk(cap == 4'b0001, "R4", "captured ir", cap, 1);
            chk(obs() == prev, "R5", "decode before update", obs(), prev);
            finish_ir();
            chk(obs() == exp_dec(op[3:0]), "R3", $sformatf("decode op %0d", op),
                obs(), exp_dec(op[3:0]));
            prev = exp_dec(op[3:0]);
        end

        // R4: shift stage passes tdi through after four bits
        shift_ir(4'b1010, cap);
        finish_ir();
        shift_ir(4'b1111, cap);
        chk(cap == 4'b0001, "R4", "recapture after update", cap, 1);
        finish_ir();

        // R6: identification readout
        load_ir(4'b1110);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_VAL, "R6", "idcode", dout[31:0], ID_VAL);

        // R7: bypass for BYPASS, CLAMP, CLAMPZ and an undefined code
        foreach (cap[k]) begin end
        for (int t = 0; t < 4; t++) begin
            logic [3:0] ops [4];
            logic [7:0] pat;
            logic [8:0] expv;
            ops = '{4'b1111, 4'b0101, 4'b1001, 4'b0110};
            load_ir(ops[t]);
            pat = 8'hA5 ^ 8'(t * 37);
            scan_dr(9, {55'h0, 1'b0, pat}, dout);
            expv = {pat, 1'b0};
            chk(dout[8:0] == expv, "R7", $sformatf("bypass op %0h", ops[t]), dout[8:0], expv);
        end

        // R8/R9/R10: boundary path under SAMPLE and EXTEST, strobes per state
        for (int t = 0; t < 2; t++) begin
            logic [5:0] pat;
            load_ir(t == 0 ? 4'b0011 : 4'b0000);
            pat = (t == 0) ? 6'b101100 : 6'b010011;
            clk(1, 0); clk(0, 0);
            chk({capture_dr, shift_dr, update_dr} == 3'b100, "R9", "capture strobe",
                {capture_dr, shift_dr, update_dr}, 4);
            clk(0, 0);
            chk({capture_dr, shift_dr, update_dr} == 3'b010, "R9", "shift strobe",
                {capture_dr, shift_dr, update_dr}, 2);
            chk(tdo_en == 1'b1, "R8", "tdo_en in shift", tdo_en, 1);
            for (int i = 0; i < 6; i++) begin
                bsr_tdo = pat[i];
                clk(0, 0);
                chk(tdo == pat[i], "R10", "boundary tdo", tdo, pat[i]);
            end
            clk(1, 0);
            chk(tdo_en == 1'b0, "R8", "tdo_en in exit", tdo_en, 0);
            clk(1, 0);
            chk({capture_dr, shift_dr, update_dr} == 3'b001, "R9", "update strobe",
                {capture_dr, shift_dr, update_dr}, 1);
            clk(0, 0);
        end

        // R2: five ones from Shift-DR and from Pause-IR
        load_ir(4'b1111);
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 5; i++) clk(1, 0);
        clk(0, 0);
        chk(dr_sel == 2'd2, "R2", "reset from shift-dr", dr_sel, 2);
        load_ir(4'b0101);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0); clk(1, 0); clk(0, 0);
        for (int i = 0; i < 5; i++) clk(1, 0);
        clk(0, 0);
        chk(obs() == exp_dec(4'b1110), "R2", "reset from pause-ir", obs(), exp_dec(4'b1110));

        // R1: asynchronous reset mid-operation
        load_ir(4'b1001);
        trst_n = 1'b0; #0.5;
        chk(dr_sel == 2'd2 && !bs_hiz, "R1", "async reset", obs(), exp_dec(4'b1110));
        #0.5 trst_n = 1'b1;
        clk(0, 0);
        chk(obs() == exp_dec(4'b1110), "R1", "after async reset", obs(), exp_dec(4'b1110));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule